// File: doc/BRIEF.md
# Process-Tagged Translation Buffer

This block is a fully associative translation buffer that turns a virtual page number into a physical frame number. Every entry's tag holds a virtual page number and a process identifier. A context switch therefore needs no flush, because a translation that belongs to one process never hits for another. When software recycles a process identifier, one control pulse removes every ordinary entry that still carries it. A global flush clears the whole buffer.

A lookup presents a page number, the current process identifier, an access kind and a privilege flag. In the same cycle the block answers with:
- hit and miss;
- the frame number;
- a permission fault;
- a pulse that marks the first store to a clean page.

On that pulse the entry's dirty bit is set at the next clock edge.

Refill is software managed. An ordinary fill goes to a round-robin victim that never lands on the reserved low slots. A system fill rotates only among those reserved slots. Reserved entries are global, which means they match any process identifier. Each entry also carries a size bit. A large page ignores a fixed number of low page-number bits in the compare and passes them through into the frame number.

Top module: `asid_tlb`

## Requirements
- R1: After reset is asserted (asynchronously, active low) and released, no lookup hits until a fill happens.
- R2: A valid lookup (`lk_valid`=1) whose page number and process identifier match a valid ordinary entry gives `lk_hit`=1, `lk_miss`=0 and that entry's frame number in the same cycle. With no match, the result is `lk_hit`=0 and `lk_miss`=1.
- R3: An ordinary entry never hits for a lookup whose process identifier differs from the one it was filled with.
- R4: An entry written with `fill_sys`=1 matches on page number alone, whatever the lookup's process identifier. It also survives a process-identifier invalidation.
- R5: A pulse on `inv_valid` invalidates every ordinary entry tagged with `inv_pid` from the next cycle on. Entries with other identifiers are left intact.
- R6: `flush_all` invalidates every entry, reserved ones included, from the next cycle on.
- R7: For an entry filled with `fill_large`=1, the low LARGE_BITS page-number bits are not compared. The low LARGE_BITS bits of `lk_pfn` are then taken from `lk_vpn`.
- R8: Access encoding on `lk_acc` is 0 load, 1 store, 2 fetch, and 3 is treated as a load. `lk_fault`=1 on a hit in any of these cases:
  - `lk_kernel`=0 and the entry's user bit is 0;
  - a store and the entry's write bit is 0;
  - a fetch and the entry's execute bit is 0.
- R9: A hit store with no fault on an entry whose dirty bit is clear raises `lk_dirty_upd` in that cycle and sets the dirty bit. Later stores to that entry leave `lk_dirty_upd` low, and so does a faulting store.
- R10: Ordinary fills go to slots RSV, RSV+1, … ENTRIES-1 and then wrap back to RSV, never to a reserved slot. A fill overwrites the slot's old translation.
- R11: When several valid entries match one lookup, the one with the lowest slot index supplies the result.
- R12: Within one cycle the updates take effect in a fixed order, with the later one winning:
  - invalidation first;
  - then the fill, so an entry filled while its identifier is being invalidated stays valid;
  - then the flush, which wins over everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Current process identifier |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_kernel | input | 1 | Privileged access |
| lk_hit | output | 1 | Lookup matched |
| lk_miss | output | 1 | Lookup requested and not matched |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| lk_fault | output | 1 | Permission violation on a hit |
| lk_dirty_upd | output | 1 | First clean-to-dirty store on this entry |
| fill_valid | input | 1 | Write one translation |
| fill_sys | input | 1 | Write it to a reserved global slot |
| fill_vpn | input | VPN_W | Page number to store |
| fill_pid | input | PID_W | Process identifier to store |
| fill_pfn | input | PFN_W | Frame number to store |
| fill_large | input | 1 | Large page |
| fill_user | input | 1 | User mode access allowed |
| fill_write | input | 1 | Store allowed |
| fill_exec | input | 1 | Fetch allowed |
| flush_all | input | 1 | Invalidate all entries |
| inv_valid | input | 1 | Invalidate ordinary entries of `inv_pid` |
| inv_pid | input | PID_W | Recycled process identifier |

## Verification
The checker relies on a few properties of the inputs. Lookup inputs are stable during a cycle. A large-page fill is given a page number whose masked low bits are zero, and no store lookup is aimed at a page that is being refilled in the same cycle. The stimulus keeps to this by changing inputs only on the falling edge and by using large-page fill addresses aligned to the large size. It issues simultaneous fill, invalidate and flush only in the directed ordering tests, where the properties already exclude those cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } acc_e;
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int RSV     = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic             fill_sys,
  output logic [IDX_W-1:0] fill_idx
);
  logic [IDX_W-1:0] usr_q, usr_d, sys_q;
  logic             usr_en;

  assign usr_en = fill_en & ~fill_sys;

  always_comb begin
    usr_d = usr_q;
    if (usr_en) begin
      if (usr_q == IDX_W'(ENTRIES-1)) usr_d = IDX_W'(RSV);
      else                            usr_d = usr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      usr_q <= IDX_W'(RSV);
    else if (usr_en) usr_q <= usr_d;
  end

  generate
    if (RSV > 1) begin : g_sys_rr
      logic [IDX_W-1:0] sys_d;
      logic             sys_en;
      assign sys_en = fill_en & fill_sys;
      always_comb begin
        sys_d = sys_q;
        if (sys_en) begin
          if (sys_q == IDX_W'(RSV-1)) sys_d = '0;
          else                        sys_d = sys_q + IDX_W'(1);
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sys_q <= '0;
        else if (sys_en) sys_q <= sys_d;
      end
    end else begin : g_sys_one
      assign sys_q = '0;
    end
  endgenerate

  assign fill_idx = fill_sys ? sys_q : usr_q;
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 8,
  parameter int RSV     = 2,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 6,
  parameter int PFN_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fill_en,
  input  logic [IDX_W-1:0]               fill_idx,
  input  logic [VPN_W-1:0]               fill_vpn,
  input  logic [PID_W-1:0]               fill_pid,
  input  logic [PFN_W-1:0]               fill_pfn,
  input  logic                           fill_large,
  input  logic                           fill_user,
  input  logic                           fill_write,
  input  logic                           fill_exec,
  input  logic                           flush,
  input  logic                           inv_en,
  input  logic [PID_W-1:0]               inv_pid,
  input  logic                           dset_en,
  input  logic [IDX_W-1:0]               dset_idx,
  output logic [ENTRIES-1:0]             valid_q,
  output logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q,
  output logic [ENTRIES-1:0][PID_W-1:0]  pid_q,
  output logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q,
  output logic [ENTRIES-1:0]             large_q,
  output logic [ENTRIES-1:0]             user_q,
  output logic [ENTRIES-1:0]             write_q,
  output logic [ENTRIES-1:0]             exec_q,
  output logic [ENTRIES-1:0]             dirty_q
);
  logic [ENTRIES-1:0] valid_d, dirty_d;
  logic               state_en;

  assign state_en = fill_en | flush | inv_en | dset_en;

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (dset_en) dirty_d[dset_idx] = 1'b1;
    if (inv_en) begin
      for (int i = RSV; i < ENTRIES; i++)
        if (pid_q[i] == inv_pid) valid_d[i] = 1'b0;
    end
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      dirty_d[fill_idx] = 1'b0;
    end
    if (flush) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[fill_idx]   <= fill_vpn;
      pid_q[fill_idx]   <= fill_pid;
      pfn_q[fill_idx]   <= fill_pfn;
      large_q[fill_idx] <= fill_large;
      user_q[fill_idx]  <= fill_user;
      write_q[fill_idx] <= fill_write;
      exec_q[fill_idx]  <= fill_exec;
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES    = 8,
  parameter int RSV        = 2,
  parameter int VPN_W      = 20,
  parameter int PID_W      = 6,
  parameter int LARGE_BITS = 4,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  input  logic [ENTRIES-1:0][PID_W-1:0] pid_q,
  input  logic [ENTRIES-1:0]            large_q,
  input  logic [VPN_W-1:0]              lk_vpn,
  input  logic [PID_W-1:0]              lk_pid,
  output logic                          any_match,
  output logic [IDX_W-1:0]              match_idx
);
  localparam logic [VPN_W-1:0] LOW_MASK = VPN_W'((1 << LARGE_BITS) - 1);

  logic [ENTRIES-1:0] match;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      logic [VPN_W-1:0] care;
      logic             vpn_eq, pid_eq;
      assign care   = large_q[i] ? ~LOW_MASK : '1;
      assign vpn_eq = ((vpn_q[i] ^ lk_vpn) & care) == '0;
      if (i < RSV) begin : g_global
        assign pid_eq = 1'b1;
      end else begin : g_private
        assign pid_eq = (pid_q[i] == lk_pid);
      end
      assign match[i] = valid_q[i] & vpn_eq & pid_eq;
    end
  endgenerate

  always_comb begin
    match_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (match[i]) match_idx = IDX_W'(i);
  end

  assign any_match = |match;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES    = 8,
  parameter int RSV        = 2,
  parameter int VPN_W      = 20,
  parameter int PID_W      = 6,
  parameter int PFN_W      = 16,
  parameter int LARGE_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [1:0]       lk_acc,
  input  logic             lk_kernel,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_fault,
  output logic             lk_dirty_upd,
  input  logic             fill_valid,
  input  logic             fill_sys,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_large,
  input  logic             fill_user,
  input  logic             fill_write,
  input  logic             fill_exec,
  input  logic             flush_all,
  input  logic             inv_valid,
  input  logic [PID_W-1:0] inv_pid
);
  import tlb_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic                          rst_sync_n;
  logic [IDX_W-1:0]              fill_idx, hit_idx;
  logic                          any_match;
  logic [ENTRIES-1:0]            valid_q, large_q, user_q, write_q, exec_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PID_W-1:0] pid_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [PFN_W-1:0]              sel_pfn;
  acc_e                          acc;
  logic                          is_store, is_fetch, deny_user, deny_write, deny_exec;

  tlb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  tlb_victim #(.ENTRIES(ENTRIES), .RSV(RSV)) u_victim (
    .clk(clk), .rst_n(rst_sync_n), .fill_en(fill_valid), .fill_sys(fill_sys),
    .fill_idx(fill_idx)
  );

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .RSV(RSV), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .fill_en(fill_valid), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_pid(fill_pid), .fill_pfn(fill_pfn), .fill_large(fill_large),
    .fill_user(fill_user), .fill_write(fill_write), .fill_exec(fill_exec),
    .flush(flush_all), .inv_en(inv_valid), .inv_pid(inv_pid),
    .dset_en(lk_dirty_upd), .dset_idx(hit_idx),
    .valid_q(valid_q), .vpn_q(vpn_q), .pid_q(pid_q), .pfn_q(pfn_q),
    .large_q(large_q), .user_q(user_q), .write_q(write_q), .exec_q(exec_q),
    .dirty_q(dirty_q)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .RSV(RSV), .VPN_W(VPN_W), .PID_W(PID_W), .LARGE_BITS(LARGE_BITS)
  ) u_match (
    .valid_q(valid_q), .vpn_q(vpn_q), .pid_q(pid_q), .large_q(large_q),
    .lk_vpn(lk_vpn), .lk_pid(lk_pid), .any_match(any_match), .match_idx(hit_idx)
  );

  assign acc      = acc_e'(lk_acc);
  assign is_store = (acc == ACC_STORE);
  assign is_fetch = (acc == ACC_FETCH);

  assign lk_hit  = lk_valid & any_match;
  assign lk_miss = lk_valid & ~any_match;

  // large pages pass the low page-number bits straight into the frame number
  assign sel_pfn = pfn_q[hit_idx];
  assign lk_pfn  = large_q[hit_idx]
                 ? {sel_pfn[PFN_W-1:LARGE_BITS], lk_vpn[LARGE_BITS-1:0]}
                 : sel_pfn;

  assign deny_user  = ~lk_kernel & ~user_q[hit_idx];
  assign deny_write = is_store & ~write_q[hit_idx];
  assign deny_exec  = is_fetch & ~exec_q[hit_idx];
  assign lk_fault   = lk_hit & (deny_user | deny_write | deny_exec);

  assign lk_dirty_upd = lk_hit & is_store & ~lk_fault & ~dirty_q[hit_idx];
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int RSV     = 2,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic [PID_W-1:0] lk_pid,
  input logic [1:0]       lk_acc,
  input logic             lk_hit,
  input logic             lk_fault,
  input logic             lk_dirty_upd,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PID_W-1:0] fill_pid,
  input logic             flush_all,
  input logic             inv_valid,
  input logic [PID_W-1:0] inv_pid,
  input logic [IDX_W-1:0] hit_idx
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit); // R6

  AST_INV_PID_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid && !flush_all) |=>
      !(lk_hit && lk_pid == $past(inv_pid) && hit_idx >= IDX_W'(RSV))); // R5

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_all) |=>
      (!(lk_valid && lk_vpn == $past(fill_vpn) && lk_pid == $past(fill_pid)) || lk_hit)); // R12

  AST_DIRTY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_dirty_upd |-> (lk_hit && lk_acc == 2'd1 && !lk_fault)); // R9

  AST_DIRTY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_dirty_upd && !fill_valid && !flush_all && !inv_valid) |=>
      !(lk_dirty_upd && $stable(lk_vpn) && $stable(lk_pid))); // R9

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit); // R8
endmodule

bind asid_tlb asid_tlb_chk #(
  .ENTRIES(ENTRIES), .RSV(RSV), .VPN_W(VPN_W), .PID_W(PID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
  .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_dirty_upd(lk_dirty_upd),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
  .flush_all(flush_all), .inv_valid(inv_valid), .inv_pid(inv_pid), .hit_idx(hit_idx)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int VPN_W = 20, PID_W = 6, PFN_W = 16;
  localparam logic [2:0] OP_FILL = 3'd0, OP_FSYS = 3'd1, OP_LOOK = 3'd2,
                         OP_INV = 3'd3, OP_FLSH = 3'd4;

  typedef struct packed {
    logic [2:0]       op;
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [PFN_W-1:0] pfn;    // fill value or expected frame
    logic [3:0]       attr;   // {large,user,write,exec}
    logic [1:0]       acc;
    logic             kern;
    logic [2:0]       exp;    // {hit,fault,dirty_upd}
    logic [3:0]       req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t TBL [NV] = '{
    '{OP_FILL, 20'h00010, 6'd1, 16'h00A0, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_LOOK, 20'h00010, 6'd1, 16'h00A0, 4'b0000, 2'd0, 1'b0, 3'b100, 4'd2},  // R2 hit
    '{OP_LOOK, 20'h00010, 6'd2, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd3},  // R3 other pid
    '{OP_LOOK, 20'h00011, 6'd1, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd2},  // R2 miss
    '{OP_LOOK, 20'h00010, 6'd1, 16'h00A0, 4'b0000, 2'd1, 1'b0, 3'b101, 4'd9},  // R9 first store
    '{OP_LOOK, 20'h00010, 6'd1, 16'h00A0, 4'b0000, 2'd1, 1'b0, 3'b100, 4'd9},  // R9 already dirty
    '{OP_FILL, 20'h00020, 6'd1, 16'h00B0, 4'b0100, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_LOOK, 20'h00020, 6'd1, 16'h00B0, 4'b0000, 2'd1, 1'b0, 3'b110, 4'd8},  // R8 read-only store
    '{OP_LOOK, 20'h00020, 6'd1, 16'h00B0, 4'b0000, 2'd2, 1'b0, 3'b110, 4'd8},  // R8 no exec
    '{OP_LOOK, 20'h00020, 6'd1, 16'h00B0, 4'b0000, 2'd0, 1'b0, 3'b100, 4'd8},  // R8 load ok
    '{OP_FILL, 20'h00030, 6'd1, 16'h00C0, 4'b0011, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_LOOK, 20'h00030, 6'd1, 16'h00C0, 4'b0000, 2'd0, 1'b0, 3'b110, 4'd8},  // R8 user on kernel page
    '{OP_LOOK, 20'h00030, 6'd1, 16'h00C0, 4'b0000, 2'd0, 1'b1, 3'b100, 4'd8},  // R8 kernel ok
    '{OP_FILL, 20'h00040, 6'd1, 16'h1230, 4'b1111, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_LOOK, 20'h0004B, 6'd1, 16'h123B, 4'b0000, 2'd0, 1'b0, 3'b100, 4'd7},  // R7 masked low bits
    '{OP_LOOK, 20'h0005B, 6'd1, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd7},  // R7 upper bits differ
    '{OP_FSYS, 20'h80000, 6'd3, 16'h0F00, 4'b0011, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_LOOK, 20'h80000, 6'd9, 16'h0F00, 4'b0000, 2'd0, 1'b1, 3'b100, 4'd4},  // R4 global
    '{OP_FILL, 20'h00010, 6'd2, 16'h00D0, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_INV,  20'h00000, 6'd1, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_INV,  20'h00000, 6'd3, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_LOOK, 20'h00010, 6'd1, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd5},  // R5 removed
    '{OP_LOOK, 20'h00040, 6'd1, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd5},  // R5 large removed
    '{OP_LOOK, 20'h00010, 6'd2, 16'h00D0, 4'b0000, 2'd0, 1'b0, 3'b100, 4'd5},  // R5 other pid kept
    '{OP_LOOK, 20'h80000, 6'd3, 16'h0F00, 4'b0000, 2'd0, 1'b1, 3'b100, 4'd4},  // R4 survives inv
    '{OP_FILL, 20'h00060, 6'd4, 16'h0333, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},  // slot 7
    '{OP_FILL, 20'h00060, 6'd4, 16'h0444, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},  // slot 2
    '{OP_LOOK, 20'h00060, 6'd4, 16'h0444, 4'b0000, 2'd0, 1'b0, 3'b100, 4'd11}, // R11 lowest index
    '{OP_FILL, 20'h00070, 6'd4, 16'h0555, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_FILL, 20'h00071, 6'd4, 16'h0556, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_FILL, 20'h00072, 6'd4, 16'h0557, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_FILL, 20'h00073, 6'd4, 16'h0558, 4'b0111, 2'd0, 1'b0, 3'b000, 4'd0},  // evicts slot 6
    '{OP_LOOK, 20'h00010, 6'd2, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd10}, // R10 victim gone
    '{OP_LOOK, 20'h80000, 6'd5, 16'h0F00, 4'b0000, 2'd0, 1'b1, 3'b100, 4'd10}, // R10 reserved kept
    '{OP_LOOK, 20'h00073, 6'd4, 16'h0558, 4'b0000, 2'd0, 1'b0, 3'b100, 4'd10}, // R10 new entry
    '{OP_FLSH, 20'h00000, 6'd0, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd0},
    '{OP_LOOK, 20'h80000, 6'd3, 16'h0000, 4'b0000, 2'd0, 1'b1, 3'b000, 4'd6},  // R6 reserved flushed
    '{OP_LOOK, 20'h00070, 6'd4, 16'h0000, 4'b0000, 2'd0, 1'b0, 3'b000, 4'd6}   // R6 ordinary flushed
  };

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             lk_valid = 1'b0, lk_kernel = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PID_W-1:0] lk_pid = '0, fill_pid = '0, inv_pid = '0;
  logic [1:0]       lk_acc = '0;
  logic             lk_hit, lk_miss, lk_fault, lk_dirty_upd;
  logic [PFN_W-1:0] lk_pfn, fill_pfn = '0;
  logic             fill_valid = 1'b0, fill_sys = 1'b0, fill_large = 1'b0;
  logic             fill_user = 1'b0, fill_write = 1'b0, fill_exec = 1'b0;
  logic             flush_all = 1'b0, inv_valid = 1'b0;
  int               n_chk = 0, n_bad = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;  // 8 time-unit period: 125 MHz at 1 ns

  asid_tlb u_asid_tlb (.*);

  task automatic drive(input vec_t v, input bit also_inv, input bit also_flush);
    @(negedge clk);
    lk_valid   = (v.op == OP_LOOK);
    lk_vpn     = v.vpn;
    lk_pid     = v.pid;
    lk_acc     = v.acc;
    lk_kernel  = v.kern;
    fill_valid = (v.op == OP_FILL) || (v.op == OP_FSYS);
    fill_sys   = (v.op == OP_FSYS);
    fill_vpn   = v.vpn;
    fill_pid   = v.pid;
    fill_pfn   = v.pfn;
    {fill_large, fill_user, fill_write, fill_exec} = v.attr;
    inv_valid  = (v.op == OP_INV) || also_inv;
    inv_pid    = v.pid;
    flush_all  = (v.op == OP_FLSH) || also_flush;
    if (v.op == OP_LOOK) begin
      #3;
      n_chk++;
      if ({lk_hit, lk_fault, lk_dirty_upd} != v.exp || lk_miss != !v.exp[2] ||
          (v.exp[2] && lk_pfn != v.pfn)) begin
        n_bad++;
        $display("FAIL R%0d: vpn=%h pid=%0d hit/fault/dupd=%b miss=%b pfn=%h expected %b miss=%b pfn=%h",
                 v.req, v.vpn, v.pid, {lk_hit, lk_fault, lk_dirty_upd}, lk_miss, lk_pfn,
                 v.exp, !v.exp[2], v.pfn);
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0; flush_all = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0; flush_all = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic vec_t mk(input logic [2:0] op, input logic [VPN_W-1:0] vpn,
                              input logic [PID_W-1:0] pid, input logic [PFN_W-1:0] pfn,
                              input logic [2:0] exp, input logic [3:0] req);
    vec_t v;
    v = '{op, vpn, pid, pfn, 4'b0111, 2'd0, 1'b0, exp, req};
    return v;
  endfunction

  initial begin
    do_reset();
    // R1: empty after reset
    drive(mk(OP_LOOK, 20'h00000, 6'd0, 16'h0, 3'b000, 4'd1), 0, 0);
    drive(mk(OP_LOOK, 20'h80000, 6'd3, 16'h0, 3'b000, 4'd1), 0, 0);

    for (int i = 0; i < NV; i++) drive(TBL[i], 0, 0);

    // R12: fill and invalidate of the same pid in one cycle, fill survives
    drive(mk(OP_FILL, 20'h00090, 6'd7, 16'h0777, 3'b000, 4'd0), 1, 0);
    drive(mk(OP_LOOK, 20'h00090, 6'd7, 16'h0777, 3'b100, 4'd12), 0, 0);
    // R12: fill together with flush, flush wins
    drive(mk(OP_FILL, 20'h00091, 6'd7, 16'h0778, 3'b000, 4'd0), 0, 1);
    drive(mk(OP_LOOK, 20'h00091, 6'd7, 16'h0000, 3'b000, 4'd12), 0, 0);
    drive(mk(OP_LOOK, 20'h00090, 6'd7, 16'h0000, 3'b000, 4'd12), 0, 0);

    // R1: reset in the middle of operation removes translations
    drive(mk(OP_FILL, 20'h000A0, 6'd2, 16'h0AAA, 3'b000, 4'd0), 0, 0);
    drive(mk(OP_LOOK, 20'h000A0, 6'd2, 16'h0AAA, 3'b100, 4'd2), 0, 0);
    do_reset();
    drive(mk(OP_LOOK, 20'h000A0, 6'd2, 16'h0000, 3'b000, 4'd1), 0, 0);
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule